// File: doc/BRIEF.md
# Processor-Port Memory Bank Decoder

This block sits between a 16-bit CPU address bus and the memories and peripherals of a small home-computer style system. For every access it picks exactly one target: main RAM, one of three ROMs (BASIC, KERNAL, character), one of five I/O devices, or the on-chip processor port. It also produces the local offset that the target needs. Which ROMs and whether the I/O window are visible depends on the low three bits of the processor port register, which is stored inside the block at address 0x0001.

Targets are reported through a one-hot select vector and a shared index output. Both are combinational from the current address and the registered banking mode. A write to the port therefore changes the map starting with the access that follows it. Writes never select a ROM. Where a ROM shadows an address, the write goes to RAM. Only the I/O window takes writes away from RAM. The interface is a plain per-cycle strobe with no back-pressure: every cycle with `acc_en` high is one access and is decoded in that same cycle.

Top module: `bank_decoder`

## Requirements
- R1: After reset the port byte reads 0x37, which selects banking mode 7.
- R2: A write to address 0x0001 stores the whole byte into the port register at the next clock edge, and the new mode applies from the next access onward. Any other access leaves the port byte unchanged. An access to address 0x0001 selects only the port target (select bit 9) and sets the index to 0.
- R3: Visibility per mode (mode = port bits 2:0). Modes 0 and 4: nothing but RAM. Mode 1: character ROM. Mode 2: character ROM and KERNAL. Mode 3: BASIC, character ROM and KERNAL. Mode 5: I/O. Mode 6: KERNAL and I/O. Mode 7: BASIC, KERNAL and I/O.
- R4: A read in 0xA000–0xBFFF selects BASIC (bit 1) with index addr−0xA000 when BASIC is visible. Otherwise it selects RAM.
- R5: A read in 0xE000–0xFFFF selects KERNAL (bit 2) with index addr−0xE000 when KERNAL is visible. Otherwise it selects RAM.
- R6: In 0xD000–0xDFFF, I/O takes precedence when visible. Otherwise a read selects character ROM (bit 3) with index addr−0xD000 when that ROM is visible. Otherwise the access selects RAM.
- R7: I/O sub-decode, with index = the masked low address bits. Video (bit 4) is at 0xD000–0xD3FF with index addr[5:0] (mirror every 64). Sound (bit 5) is at 0xD400–0xD7FF with index addr[7:0]. Colour RAM (bit 6) is at 0xD800–0xDBFF with index addr[9:0]. Timer chip 1 (bit 7) is at 0xDC00–0xDCFF and timer chip 2 (bit 8) is at 0xDD00–0xDDFF, each with index addr[3:0] (mirror every 16). 0xDE00–0xDFFF selects nothing.
- R8: A write never selects BASIC, KERNAL or character ROM. The address that would have shown ROM selects RAM (bit 0) instead. I/O writes select the device as in R7.
- R9: With `acc_en` low all select bits and the index are 0. With `acc_en` high at most one select bit is set.
- R10: Addresses 0x0000, 0x0002–0x9FFF and 0xC000–0xCFFF always select RAM with index 0, in every mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_en | input | 1 | Access strobe for this cycle |
| acc_we | input | 1 | 1 = write, 0 = read |
| acc_addr | input | 16 | CPU address |
| acc_wdata | input | 8 | Write data (used for port writes) |
| tgt_sel | output | 10 | One-hot target: 0 RAM, 1 BASIC, 2 KERNAL, 3 char ROM, 4 video, 5 sound, 6 colour, 7 timer 1, 8 timer 2, 9 port |
| local_idx | output | 13 | Offset inside the selected ROM or device register file |
| port_byte | output | 8 | Stored processor port byte (readback value) |

## Verification
The checker watches several properties on every cycle. It checks that the select vector is one-hot or zero and that it is zero while idle. It checks that writes never reach a ROM and that low memory always maps to RAM. It checks that mode 0 shows RAM only and that video and timer indices stay inside their mirror windows. It also checks that the port byte changes only after a port write and then holds the written value. Only the bench scenarios can show that the full eight-mode table is correct at every region boundary. The same applies to the exact ROM and device offsets, the dead 0xDE00–0xDFFF area, and a bank switch taking hold on the very next access.

// File: rtl/bank_pkg.sv
package bank_pkg;

  localparam int TGT_N    = 10;
  localparam int IO_DEV_N = 5;

  typedef enum int unsigned {
    T_RAM    = 0,
    T_BASIC  = 1,
    T_KERNAL = 2,
    T_CHAR   = 3,
    T_VIDEO  = 4,
    T_SOUND  = 5,
    T_COLOR  = 6,
    T_TIMER1 = 7,
    T_TIMER2 = 8,
    T_PORT   = 9
  } tgt_e;

  typedef struct packed {
    logic basic;
    logic chr;
    logic kernal;
    logic io;
  } vis_t;

  // banking table indexed by the low three port bits
  function automatic vis_t mode_flags(input logic [2:0] m);
    vis_t v;
    v = '0;
    unique case (m)
      3'd1: v.chr = 1'b1;
      3'd2: begin v.chr = 1'b1; v.kernal = 1'b1; end
      3'd3: begin v.basic = 1'b1; v.chr = 1'b1; v.kernal = 1'b1; end
      3'd5: v.io = 1'b1;
      3'd6: begin v.kernal = 1'b1; v.io = 1'b1; end
      3'd7: begin v.basic = 1'b1; v.kernal = 1'b1; v.io = 1'b1; end
      default: v = '0;
    endcase
    return v;
  endfunction

  // I/O window device k: address bits [11:0] match under mask
  function automatic logic [11:0] io_match_mask(input int k);
    case (k)
      0, 1, 2: return 12'hC00;
      default: return 12'hF00;
    endcase
  endfunction

  function automatic logic [11:0] io_match_val(input int k);
    case (k)
      0:       return 12'h000;
      1:       return 12'h400;
      2:       return 12'h800;
      3:       return 12'hC00;
      default: return 12'hD00;
    endcase
  endfunction

  function automatic logic [11:0] io_idx_mask(input int k);
    case (k)
      0:       return 12'h03F;
      1:       return 12'h0FF;
      2:       return 12'h3FF;
      default: return 12'h00F;
    endcase
  endfunction

endpackage

// File: rtl/bank_port_reg.sv
module bank_port_reg #(
  parameter int              DATA_W    = 8,
  parameter logic [DATA_W-1:0] RESET_VAL = 8'h37
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_stb,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      q <= RESET_VAL;
    else if (wr_stb) q <= wdata;
  end
endmodule

// File: rtl/bank_mode_table.sv
module bank_mode_table
  import bank_pkg::*;
#(
  parameter int MODE_W = 3
) (
  input  logic [MODE_W-1:0] mode,
  output vis_t              vis
);
  localparam int ENTRIES = 1 << MODE_W;

  vis_t tbl [ENTRIES];

  for (genvar m = 0; m < ENTRIES; m++) begin : g_entry
    assign tbl[m] = mode_flags(3'(m));
  end

  assign vis = tbl[mode];
endmodule

// File: rtl/bank_io_subdec.sv
module bank_io_subdec
  import bank_pkg::*;
#(
  parameter int WIN_W = 12
) (
  input  logic [WIN_W-1:0]    win_addr,
  output logic [IO_DEV_N-1:0] hit,
  output logic [WIN_W-1:0]    dev_idx
);
  logic [WIN_W-1:0] part [IO_DEV_N];

  for (genvar k = 0; k < IO_DEV_N; k++) begin : g_dev
    assign hit[k]  = (win_addr & io_match_mask(k)) == io_match_val(k);
    assign part[k] = hit[k] ? (win_addr & io_idx_mask(k)) : '0;
  end

  always_comb begin
    dev_idx = '0;
    for (int k = 0; k < IO_DEV_N; k++) dev_idx = dev_idx | part[k];
  end
endmodule

// File: rtl/bank_decoder.sv
module bank_decoder
  import bank_pkg::*;
#(
  parameter int              DATA_W     = 8,
  parameter logic [DATA_W-1:0] PORT_RESET = 8'h37,
  parameter int              IDX_W      = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_en,
  input  logic              acc_we,
  input  logic [15:0]       acc_addr,
  input  logic [DATA_W-1:0] acc_wdata,
  output logic [TGT_N-1:0]  tgt_sel,
  output logic [IDX_W-1:0]  local_idx,
  output logic [DATA_W-1:0] port_byte
);
  localparam int          MODE_W    = 3;
  localparam int          WIN_W     = 12;
  localparam logic [15:0] PORT_ADDR = 16'h0001;

  logic                is_port, in_basic, in_kernal, in_dwin;
  logic                port_wr;
  vis_t                vis;
  logic [IO_DEV_N-1:0] io_hit;
  logic [WIN_W-1:0]    io_idx;

  assign is_port   = acc_addr == PORT_ADDR;
  assign in_basic  = acc_addr[15:13] == 3'b101;
  assign in_kernal = acc_addr[15:13] == 3'b111;
  assign in_dwin   = acc_addr[15:12] == 4'hD;
  assign port_wr   = acc_en && acc_we && is_port;

  bank_port_reg #(.DATA_W(DATA_W), .RESET_VAL(PORT_RESET)) u_port (
    .clk(clk), .rst_n(rst_n), .wr_stb(port_wr), .wdata(acc_wdata), .q(port_byte)
  );

  bank_mode_table #(.MODE_W(MODE_W)) u_tbl (
    .mode(port_byte[MODE_W-1:0]), .vis(vis)
  );

  bank_io_subdec #(.WIN_W(WIN_W)) u_io (
    .win_addr(acc_addr[WIN_W-1:0]), .hit(io_hit), .dev_idx(io_idx)
  );

  always_comb begin
    tgt_sel   = '0;
    local_idx = '0;
    if (acc_en) begin
      if (is_port) begin
        tgt_sel[T_PORT] = 1'b1;
      end else if (in_basic && vis.basic && !acc_we) begin
        tgt_sel[T_BASIC] = 1'b1;
        local_idx        = IDX_W'(acc_addr[12:0]);
      end else if (in_kernal && vis.kernal && !acc_we) begin
        tgt_sel[T_KERNAL] = 1'b1;
        local_idx         = IDX_W'(acc_addr[12:0]);
      end else if (in_dwin && vis.io) begin
        tgt_sel[T_VIDEO +: IO_DEV_N] = io_hit;
        local_idx                    = IDX_W'(io_idx);
      end else if (in_dwin && vis.chr && !acc_we) begin
        tgt_sel[T_CHAR] = 1'b1;
        local_idx       = IDX_W'(acc_addr[11:0]);
      end else begin
        tgt_sel[T_RAM] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/bank_decoder_chk.sv
module bank_decoder_chk
  import bank_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int IDX_W  = 13
) (
  input logic              clk,
  input logic              rst_n,
  input logic              acc_en,
  input logic              acc_we,
  input logic [15:0]       acc_addr,
  input logic [DATA_W-1:0] acc_wdata,
  input logic [TGT_N-1:0]  tgt_sel,
  input logic [IDX_W-1:0]  local_idx,
  input logic [DATA_W-1:0] port_byte
);
  logic pw, low_ram;
  assign pw      = acc_en && acc_we && (acc_addr == 16'h0001);
  assign low_ram = acc_en && (acc_addr != 16'h0001) &&
                   ((acc_addr < 16'hA000) || (acc_addr[15:12] == 4'hC));

  AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(tgt_sel)); // R9
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_en |-> (tgt_sel == '0 && local_idx == '0)); // R9
  AST_PORT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    pw |=> port_byte == $past(acc_wdata)); // R2
  AST_PORT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !pw |=> $stable(port_byte)); // R2
  AST_WRITE_NO_ROM: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_en && acc_we) |-> (tgt_sel[T_BASIC] == 1'b0 && tgt_sel[T_KERNAL] == 1'b0
                            && tgt_sel[T_CHAR] == 1'b0)); // R8
  AST_LOW_RAM: assert property (@(posedge clk) disable iff (!rst_n)
    low_ram |-> tgt_sel == (TGT_N'(1) << T_RAM)); // R10
  AST_MODE0_RAM: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_en && port_byte[2:0] == 3'd0 && acc_addr != 16'h0001) |->
      tgt_sel == (TGT_N'(1) << T_RAM)); // R3
  AST_VIDEO_MIRROR: assert property (@(posedge clk) disable iff (!rst_n)
    tgt_sel[T_VIDEO] |-> local_idx < IDX_W'(64)); // R7
  AST_TIMER_MIRROR: assert property (@(posedge clk) disable iff (!rst_n)
    (tgt_sel[T_TIMER1] || tgt_sel[T_TIMER2]) |-> local_idx < IDX_W'(16)); // R7
endmodule

bind bank_decoder bank_decoder_chk #(.DATA_W(DATA_W), .IDX_W(IDX_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .acc_en(acc_en), .acc_we(acc_we),
  .acc_addr(acc_addr), .acc_wdata(acc_wdata), .tgt_sel(tgt_sel),
  .local_idx(local_idx), .port_byte(port_byte)
);

// File: tb/bank_decoder_tb_top.sv
module bank_decoder_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        acc_en = 1'b0, acc_we = 1'b0;
  logic [15:0] acc_addr = '0;
  logic [7:0]  acc_wdata = '0;
  logic [9:0]  tgt_sel;
  logic [12:0] local_idx;
  logic [7:0]  port_byte;

  int    n_chk = 0, n_bad = 0;
  logic  [22:0] exp_q[$];
  string tag_q[$];
  logic  [7:0] mdl_port = 8'h37;
  bit    done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bank_decoder dut_i (
    .clk(clk), .rst_n(rst_n), .acc_en(acc_en), .acc_we(acc_we),
    .acc_addr(acc_addr), .acc_wdata(acc_wdata), .tgt_sel(tgt_sel),
    .local_idx(local_idx), .port_byte(port_byte)
  );

  function automatic void check(string tag, logic [22:0] act, logic [22:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endfunction

  // reference map written from the requirement text
  function automatic logic [22:0] ref_map(logic [7:0] pb, logic we, logic [15:0] a);
    logic [2:0] m;
    bit b_on, c_on, k_on, i_on;
    logic [9:0]  s;
    logic [12:0] x;
    m = pb[2:0];
    b_on = (m == 3 || m == 7);
    c_on = (m == 1 || m == 2 || m == 3);
    k_on = (m == 2 || m == 3 || m == 6 || m == 7);
    i_on = (m == 5 || m == 6 || m == 7);
    s = 10'b1; x = '0;
    if (a == 16'h0001) s = 10'h200;
    else if (a >= 16'hA000 && a <= 16'hBFFF && b_on && !we) begin s = 10'h002; x = 13'(a - 16'hA000); end
    else if (a >= 16'hE000 && k_on && !we) begin s = 10'h004; x = 13'(a - 16'hE000); end
    else if (a >= 16'hD000 && a <= 16'hDFFF && i_on) begin
      if (a < 16'hD400)      begin s = 10'h010; x = 13'(a % 64); end
      else if (a < 16'hD800) begin s = 10'h020; x = 13'(a % 256); end
      else if (a < 16'hDC00) begin s = 10'h040; x = 13'(a - 16'hD800); end
      else if (a < 16'hDD00) begin s = 10'h080; x = 13'(a % 16); end
      else if (a < 16'hDE00) begin s = 10'h100; x = 13'(a % 16); end
      else s = 10'h000;
    end
    else if (a >= 16'hD000 && a <= 16'hDFFF && c_on && !we) begin s = 10'h008; x = 13'(a - 16'hD000); end
    return {s, x};
  endfunction

  function automatic string region_tag(logic [15:0] a, logic we);
    if (a == 16'h0001) return "R2";
    if (we && a >= 16'hA000) return "R8";
    if (a >= 16'hA000 && a <= 16'hBFFF) return "R4";
    if (a >= 16'hE000) return "R5";
    if (a >= 16'hD000 && a <= 16'hDFFF) return (a < 16'hDE00) ? "R7" : "R6";
    return "R10";
  endfunction

  task automatic access(logic we, logic [15:0] a, logic [7:0] d, string tag);
    @(negedge clk); #1;
    acc_en = 1'b1; acc_we = we; acc_addr = a; acc_wdata = d;
    exp_q.push_back(ref_map(mdl_port, we, a));
    tag_q.push_back(tag);
    if (we && a == 16'h0001) mdl_port = d;
  endtask

  task automatic idle();
    @(negedge clk); #1;
    acc_en = 1'b0; acc_we = 1'b0; acc_addr = 16'hA123;
    exp_q.push_back('0);
    tag_q.push_back("R9");
  endtask

  // monitor: compares each produced decode against the scoreboard
  initial forever begin
    @(negedge clk); #2;
    if (exp_q.size() > 0) check(tag_q.pop_front(), {tgt_sel, local_idx}, exp_q.pop_front());
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  localparam int NA = 18;
  logic [15:0] probe [NA] = '{16'h0000, 16'h1234, 16'h9FFF, 16'hA000, 16'hBFFF,
    16'hC800, 16'hD000, 16'hD07F, 16'hD3C5, 16'hD455, 16'hD9AB, 16'hDC1F,
    16'hDDF3, 16'hDE10, 16'hDFFF, 16'hE000, 16'hFFFF, 16'hCFFF};

  initial begin
    repeat (3) @(negedge clk);
    check("R1", {15'd0, port_byte}, {15'd0, 8'h37});
    rst_n = 1'b1;
    idle();
    // R3: mode 7 first, then every mode, each swept with reads and writes
    for (int m = 7; m >= 0; m--) begin
      access(1'b1, 16'h0001, 8'(m) | 8'hA8, "R2");
      access(1'b0, 16'h0001, 8'h00, "R2");
      for (int i = 0; i < NA; i++) begin
        access(1'b0, probe[i], 8'h5A, region_tag(probe[i], 1'b0));
        access(1'b1, probe[i], 8'hC3, region_tag(probe[i], 1'b1));
      end
      idle();
    end
    // R2: full byte stored, switch takes hold on very next access
    access(1'b1, 16'h0001, 8'hF8, "R2");
    access(1'b0, 16'hE000, 8'h00, "R2");
    @(negedge clk); #2;
    check("R2", {15'd0, port_byte}, {15'd0, 8'hF8});
    access(1'b1, 16'h0001, 8'h07, "R2");
    access(1'b0, 16'hE001, 8'h00, "R2");
    access(1'b1, 16'h0000, 8'h2F, "R10");
    idle();
    @(negedge clk); #2;
    check("R2", {15'd0, port_byte}, {15'd0, 8'h07});
    idle();
    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule